// File: doc/BRIEF.md
# Center-Aligned PWM Timer

This block is a symmetric up/down timer with several compare channels. A shared counter climbs from zero to a programmed modulo value and then descends back to one, so one PWM period lasts twice the modulo value in clocks. Each channel compares the count with its own threshold. On a match it sets or clears its output, and whether it sets or clears depends on the direction the counter is moving. The resulting pulse is centered on the point where the count is at zero. It is as wide as twice the threshold.

Software programs the timer through a write-only register port. The modulo value and the thresholds are written into holding registers. The timer adopts them only at the bottom of the count, so a period already running is never disturbed. Each channel has a sticky match flag and an interrupt enable. The timer has a sticky overflow flag that is set at the top of the count. A channel can be left undriven while its flag and interrupt still work. This lets the compare act as a pure timing event.

Top module: `cpwm_timer`

## Requirements
- R1: While enabled with modulo M > 0 the count runs 0, 1, …, M, M−1, …, 1 and then repeats from 0, so the period is 2·M clocks. `count_up` is 1 for the values 0..M and 0 on the way down. With M = 0 the count stays at 0. Register map: address 0 bit 0 = enable, address 1 = modulo.
- R2: With mode 10 and a valid threshold C, the channel output is high for exactly 2·C clocks per period, centered on count 0.
- R3: The channel flag is set one clock after the count equals the channel's active threshold and stays set. `irq` is the OR over channels of flag AND interrupt enable. Channel n control is at address 4+2n, with bit 2 = interrupt enable and bits 1:0 = mode. Channel n threshold is at address 5+2n.
- R4: In mode 00, `ch_oe` is 0, the output value never changes, and matches still set the flag.
- R5: In mode 10, a match while counting down drives the output high and a match while counting up drives it low.
- R6: In mode 01 or 11, a match while counting down drives the output low and a match while counting up drives it high.
- R7: The overflow flag is set one clock after the count equals the modulo value and stays set.
- R8: Writing address 2 clears flags whose data bit is 1: bit 0 clears the overflow flag and bit 1+n clears channel n's flag. A flag set in the same clock as its clear stays set.
- R9: Modulo and threshold writes take effect only when the count next becomes 0, or at once while the timer is disabled. The period already running keeps its old top value.
- R10: While disabled the count is 0 and the channel outputs keep their last values.
- R11: If the active threshold is 0 or ≥ the modulo, an enabled driving channel holds its idle level: low for mode 10, high for mode x1. The flag is still set whenever the count reaches the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| count | output | CNT_W | Current counter value |
| count_up | output | 1 | 1 while the counter is on its rising slope |
| ovf_flag | output | 1 | Sticky overflow flag |
| ch_flag | output | NUM_CH | Sticky per-channel match flags |
| ch_out | output | NUM_CH | Channel PWM outputs |
| ch_oe | output | NUM_CH | Channel output drive enables |
| irq | output | 1 | Combined channel interrupt request |

## Verification
The hardest case to reach is a flag clear that arrives in the same clock as the event that sets the flag. To produce it, the stimulus watches the count at the falling edge and issues the overflow clear exactly when the count sits at the modulo value. A second hard case is a modulo rewrite in the middle of a period. The bench writes a smaller modulo on the rising slope, then checks that the current period still peaks at the old value and the next one peaks at the new value. Around these directed cases, a sweep covers every modulo from 0 to 6 against thresholds 0 to 7 in every mode, with a cycle-level reference model checked on every clock.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Register addresses
    localparam int unsigned A_CTRL = 0;
    localparam int unsigned A_MOD  = 1;
    localparam int unsigned A_STAT = 2;
    localparam int unsigned A_CH0  = 4;

    // Channel configuration: bit 2 irq enable, bits 1:0 output mode
    typedef struct packed {
        logic       irq_en;
        logic [1:0] mode;
    } ch_cfg_t;

    localparam int unsigned CFG_W = $bits(ch_cfg_t);

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] mod_hold,
    input  logic             tof_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             up,
    output logic [CNT_W-1:0] mod_act,
    output logic             reload,
    output logic             tof
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mod_act;
        logic             up;
        logic             tof;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       turn;

    always_comb begin
        s_d  = s_q;
        turn = s_q.up && (s_q.cnt >= s_q.mod_act);
        if (!en || s_q.mod_act == '0) begin
            s_d.cnt = '0;
        end else if (turn || !s_q.up) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (s_d.cnt == '0) begin
            s_d.up = 1'b1;
        end else if (en && turn) begin
            s_d.up = 1'b0;
        end
        reload = !en || (s_d.cnt == '0);
        if (reload) begin
            s_d.mod_act = mod_hold;
        end
        if (tof_clr) begin
            s_d.tof = 1'b0;
        end
        if (en && s_q.cnt == s_q.mod_act) begin
            s_d.tof = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, mod_act: '0, up: 1'b1, tof: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt     = s_q.cnt;
    assign up      = s_q.up;
    assign mod_act = s_q.mod_act;
    assign tof     = s_q.tof;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> s_q.cnt <= s_q.mod_act); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s_q.mod_act != '0) |=>
        (s_q.cnt == $past(s_q.cnt) + 1'b1 || s_q.cnt == $past(s_q.cnt) - 1'b1)); // R1
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> s_q.cnt == '0); // R10
    AST_TOF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tof && !tof_clr) |=> s_q.tof); // R7
    AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt != '0 |-> $stable(s_q.mod_act)); // R9

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic [CNT_W-1:0] mod_act,
    input  logic             reload,
    input  logic [CNT_W-1:0] cnv_hold,
    input  ch_cfg_t          cfg,
    input  logic             flag_clr,
    output logic             out,
    output logic             oe,
    output logic             flag,
    output logic             irq_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnv_act;
        logic             out;
        logic             flag;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      match;
    logic      valid;
    logic      drive;

    always_comb begin
        s_d   = s_q;
        match = en && (cnt == s_q.cnv_act);
        valid = (s_q.cnv_act != '0) && (s_q.cnv_act < mod_act);
        drive = (cfg.mode != 2'b00);
        if (en && drive) begin
            if (!valid) begin
                s_d.out = cfg.mode[0];
            end else if (match) begin
                s_d.out = up ? cfg.mode[0] : ~cfg.mode[0];
            end
        end
        if (flag_clr) begin
            s_d.flag = 1'b0;
        end
        if (match) begin
            s_d.flag = 1'b1;
        end
        if (reload) begin
            s_d.cnv_act = cnv_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out     = s_q.out;
    assign oe      = drive;
    assign flag    = s_q.flag;
    assign irq_req = s_q.flag & cfg.irq_en;

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == s_q.cnv_act) |=> s_q.flag); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !flag_clr) |=> s_q.flag); // R3
    AST_UNDRIVEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == 2'b00) |=> $stable(s_q.out)); // R4
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg.mode != 2'b00 && !((s_q.cnv_act != '0) && (s_q.cnv_act < mod_act)))
        |=> s_q.out == $past(cfg.mode[0])); // R11

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              count_up,
    output logic              ovf_flag,
    output logic [NUM_CH-1:0] ch_flag,
    output logic [NUM_CH-1:0] ch_out,
    output logic [NUM_CH-1:0] ch_oe,
    output logic              irq
);

    typedef struct packed {
        logic                         en;
        logic [CNT_W-1:0]             mod_hold;
        logic [NUM_CH-1:0][CNT_W-1:0] cnv_hold;
        ch_cfg_t [NUM_CH-1:0]         cfg;
    } reg_t;

    reg_t              r_d, r_q;
    logic              tof_clr;
    logic [NUM_CH-1:0] ch_clr;
    logic [NUM_CH-1:0] ch_irq;
    logic [CNT_W-1:0]  cnt;
    logic              up;
    logic [CNT_W-1:0]  mod_act;
    logic              reload;

    always_comb begin
        r_d     = r_q;
        tof_clr = wr_en && (wr_addr == ADDR_W'(A_STAT)) && wr_data[0];
        ch_clr  = '0;
        if (wr_en && wr_addr == ADDR_W'(A_CTRL)) begin
            r_d.en = wr_data[0];
        end
        if (wr_en && wr_addr == ADDR_W'(A_MOD)) begin
            r_d.mod_hold = wr_data;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            ch_clr[i] = wr_en && (wr_addr == ADDR_W'(A_STAT)) && wr_data[i+1];
            if (wr_en && wr_addr == ADDR_W'(A_CH0 + 2*i)) begin
                r_d.cfg[i] = ch_cfg_t'(wr_data[CFG_W-1:0]);
            end
            if (wr_en && wr_addr == ADDR_W'(A_CH0 + 2*i + 1)) begin
                r_d.cnv_hold[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    cpwm_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (r_q.en),
        .mod_hold (r_q.mod_hold),
        .tof_clr  (tof_clr),
        .cnt      (cnt),
        .up       (up),
        .mod_act  (mod_act),
        .reload   (reload),
        .tof      (ovf_flag)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cpwm_channel #(.CNT_W(CNT_W)) i_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (r_q.en),
            .cnt      (cnt),
            .up       (up),
            .mod_act  (mod_act),
            .reload   (reload),
            .cnv_hold (r_q.cnv_hold[g]),
            .cfg      (r_q.cfg[g]),
            .flag_clr (ch_clr[g]),
            .out      (ch_out[g]),
            .oe       (ch_oe[g]),
            .flag     (ch_flag[g]),
            .irq_req  (ch_irq[g])
        );
    end

    assign count    = cnt;
    assign count_up = up;
    assign irq      = |ch_irq;

    AST_EN_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_CTRL) && !wr_data[0]) |=> !r_q.en ##1 count == '0); // R10

endmodule

// File: tb/test_cpwm_timer.sv
module test_cpwm_timer;

    localparam int CW = 8;
    localparam int NC = 2;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] count;
    logic          count_up;
    logic          ovf_flag;
    logic [NC-1:0] ch_flag;
    logic [NC-1:0] ch_out;
    logic [NC-1:0] ch_oe;
    logic          irq;

    cpwm_timer #(.CNT_W(CW), .NUM_CH(NC), .ADDR_W(AW)) i_cpwm_timer (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
        .count, .count_up, .ovf_flag, .ch_flag, .ch_out, .ch_oe, .irq
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model, written from the requirements
    bit       m_en, m_up, m_tof;
    int       m_cnt, m_modh, m_moda;
    int       m_cnvh [NC];
    int       m_cnva [NC];
    bit [1:0] m_mode [NC];
    bit       m_ie   [NC];
    bit       m_out  [NC];
    bit       m_flag [NC];
    int       t_ncnt;
    bit       t_nup, t_rl, t_match, t_valid, t_turn;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_up = 1; m_tof = 0; m_cnt = 0; m_modh = 0; m_moda = 0;
            for (int i = 0; i < NC; i++) begin
                m_cnvh[i] = 0; m_cnva[i] = 0; m_mode[i] = 0; m_ie[i] = 0;
                m_out[i] = 0; m_flag[i] = 0;
            end
        end else begin
            t_turn = m_up && (m_cnt >= m_moda);
            if (!m_en || m_moda == 0) t_ncnt = 0;
            else if (t_turn || !m_up) t_ncnt = m_cnt - 1;
            else t_ncnt = m_cnt + 1;
            t_nup = (t_ncnt == 0) ? 1'b1 : ((m_en && t_turn) ? 1'b0 : m_up);
            t_rl = !m_en || (t_ncnt == 0);
            for (int i = 0; i < NC; i++) begin
                t_match = m_en && (m_cnt == m_cnva[i]);
                t_valid = (m_cnva[i] != 0) && (m_cnva[i] < m_moda);
                if (m_en && m_mode[i] != 0) begin
                    if (!t_valid) m_out[i] = m_mode[i][0];
                    else if (t_match) m_out[i] = m_up ? m_mode[i][0] : !m_mode[i][0];
                end
                if (wr_en && wr_addr == 2 && wr_data[i+1]) m_flag[i] = 0;
                if (t_match) m_flag[i] = 1;
                if (t_rl) m_cnva[i] = m_cnvh[i];
            end
            if (wr_en && wr_addr == 2 && wr_data[0]) m_tof = 0;
            if (m_en && m_cnt == m_moda) m_tof = 1;
            if (t_rl) m_moda = m_modh;
            m_cnt = t_ncnt;
            m_up = t_nup;
            if (wr_en) begin
                case (int'(wr_addr))
                    0: m_en = wr_data[0];
                    1: m_modh = int'(wr_data);
                    4: begin m_mode[0] = wr_data[1:0]; m_ie[0] = wr_data[2]; end
                    5: m_cnvh[0] = int'(wr_data);
                    6: begin m_mode[1] = wr_data[1:0]; m_ie[1] = wr_data[2]; end
                    7: m_cnvh[1] = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    function automatic string out_tag(input int i);
        if (m_mode[i] == 0) return "R4";
        if (!((m_cnva[i] != 0) && (m_cnva[i] < m_moda))) return "R11";
        if (m_mode[i][0]) return "R6";
        return "R5";
    endfunction

    // Continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            bit exp_irq;
            exp_irq = 0;
            chk(m_en ? "R1" : "R10", "count", int'(count), m_cnt);
            chk("R1", "count_up", int'(count_up), int'(m_up));
            chk("R7", "ovf_flag", int'(ovf_flag), int'(m_tof));
            for (int i = 0; i < NC; i++) begin
                chk("R3", $sformatf("ch_flag[%0d]", i), int'(ch_flag[i]), int'(m_flag[i]));
                chk(out_tag(i), $sformatf("ch_out[%0d]", i), int'(ch_out[i]), int'(m_out[i]));
                chk("R4", $sformatf("ch_oe[%0d]", i), int'(ch_oe[i]), int'(m_mode[i] != 0));
                exp_irq = exp_irq | (m_flag[i] & m_ie[i]);
            end
            chk("R3", "irq", int'(irq), int'(exp_irq));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset count", int'(count), 0);
        chk("R7", "reset ovf_flag", int'(ovf_flag), 0);
        chk("R3", "reset flags", int'(ch_flag), 0);
        chk("R10", "reset outputs", int'(ch_out), 0);
        chk("R3", "reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1;

        // Sweep: modulo x threshold x mode
        for (int m = 0; m <= 6; m++) begin
            for (int c = 0; c <= 7; c++) begin
                for (int k = 0; k < 4; k++) begin
                    wr(0, 0);
                    wr(1, m);
                    wr(5, c);
                    wr(7, (c + 3) % 8);
                    wr(4, (c % 2) * 4 + k);
                    wr(6, 4 + ((k + 1) % 4));
                    wr(2, 7);
                    wr(0, 1);
                    repeat (4 * m + 6) @(negedge clk);
                end
            end
        end

        // R2: pulse width 2*C, mode 10 on ch0 and mode 01 on ch1
        begin
            int hi0, lo1, guard;
            wr(0, 0); wr(1, 8); wr(5, 5); wr(7, 5); wr(4, 2); wr(6, 1); wr(0, 1);
            repeat (20) @(negedge clk);
            guard = 0;
            while (count != 0 && guard < 40) begin @(negedge clk); guard++; end
            hi0 = 0; lo1 = 0;
            for (int t = 0; t < 16; t++) begin
                if (ch_out[0]) hi0++;
                if (!ch_out[1]) lo1++;
                @(negedge clk);
            end
            chk("R2", "mode 10 high cycles per period", hi0, 10);
            chk("R6", "mode 01 low cycles per period", lo1, 10);
        end

        // R9: mid-period modulo rewrite takes effect at the next zero
        begin
            int mx, guard;
            guard = 0;
            while (!(count == 3 && count_up) && guard < 40) begin @(negedge clk); guard++; end
            wr(1, 4);
            mx = 0; guard = 0;
            while (count != 0 && guard < 40) begin
                if (int'(count) > mx) mx = int'(count);
                @(negedge clk); guard++;
            end
            chk("R9", "peak of current period", mx, 8);
            @(negedge clk);
            mx = 0; guard = 0;
            while (count != 0 && guard < 40) begin
                if (int'(count) > mx) mx = int'(count);
                @(negedge clk); guard++;
            end
            chk("R9", "peak of following period", mx, 4);
        end

        // R8: clear vs coincident set of the overflow flag
        begin
            int guard;
            wr(1, 8);
            guard = 0;
            while (count != 2 && guard < 40) begin @(negedge clk); guard++; end
            wr(2, 1);
            chk("R8", "overflow flag cleared", int'(ovf_flag), 0);
            guard = 0;
            while (!(count == 8 && count_up) && guard < 60) begin @(negedge clk); guard++; end
            chk("R7", "reached top", int'(count), 8);
            wr(2, 1);
            chk("R8", "set wins over clear", int'(ovf_flag), 1);
            guard = 0;
            while (count != 4 && guard < 40) begin @(negedge clk); guard++; end
            wr(2, 6);
            chk("R8", "channel flags cleared", int'(ch_flag), 0);
        end

        // R10: disable holds count at 0 and keeps outputs
        begin
            logic [NC-1:0] held;
            int guard;
            guard = 0;
            while (!(count == 6 && !count_up) && guard < 60) begin @(negedge clk); guard++; end
            held = ch_out;
            wr(0, 0);
            repeat (4) @(negedge clk);
            chk("R10", "disabled count", int'(count), 0);
            chk("R10", "outputs kept", int'(ch_out), int'(held));
        end

        chk_on = 0;
        summary();
    end

endmodule